// File: doc/BRIEF.md
# Saturating Rounding Variable Shifter Lane

This unit shifts one SIMD lane per transaction by a signed amount. A negative amount shifts right and a non-negative amount shifts left. The lane is 8, 16, 32 or 64 bits wide. Each request also selects:

- how the lane is interpreted: signed, unsigned, or signed input with an unsigned result;
- whether right shifts round to nearest;
- whether left-shift overflow clips to the lane range.

A sticky flag records every clipping event until it is cleared explicitly.

Requests enter on a valid/ready handshake and are computed combinationally. The result is held in a single output register. Control is a two-state machine:

- `ST_EMPTY`: the output register holds nothing.
- `ST_FULL`: the output register holds a result that has not yet been consumed.

The transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| LOAD | `ST_EMPTY` | `ST_FULL` | A request is accepted. |
| REFILL | `ST_FULL` | `ST_FULL` | The held result is consumed and a new request is accepted in the same cycle. |
| STALL | `ST_FULL` | `ST_FULL` | The consumer is not ready, so the held result stays. |
| DRAIN | `ST_FULL` | `ST_EMPTY` | The held result is consumed and no new request arrives. |

Because REFILL exists, the unit sustains one lane per cycle.

Top module: `sat_shift_lane`

## Requirements
- R1: A request accepted at a clock edge (`in_valid` and `in_ready` high) appears with `out_valid` high from that edge on. While `out_valid` is high and `out_ready` is low, `out_data` is held unchanged. After reset, `out_valid` and `sat_flag` are 0 and `in_ready` is 1.
- R2: `in_ready` equals `!out_valid || out_ready`. A new request is therefore accepted in the same cycle as the previous result is consumed, which gives back-to-back throughput of one lane per cycle.
- R3: Field encodings:
  - `in_size` 0, 1, 2 and 3 select lane widths W of 8, 16, 32 and 64 bits.
  - The lane operand is `in_src[W-1:0]`.
  - `in_amt` is an 8-bit two's-complement amount in the range -128 to 127.
  - `in_mode` 0 selects signed, 1 and 3 select unsigned, and 2 selects signed-to-unsigned.
  - The result occupies `out_data[W-1:0]`, and the bits above it are 0.
- R4: For an amount -n with n below the limit given in R6 and R7, and rounding off, signed mode shifts right arithmetically by n. The other modes shift the lane right logically by n.
- R5: With rounding on, a right shift by n yields floor((x + 2^(n-1)) / 2^n), where x is the lane value under the mode's interpretation.
- R6: In signed mode, an amount of -W or less yields 0 when rounding is on. With rounding off it yields the sign fill: all ones for a negative lane, otherwise 0.
- R7: In unsigned and signed-to-unsigned modes, an amount of -W or less (-(W+1) or less when rounding is on) yields 0.
- R8: For a left amount below W, the result is the lane shifted and cut to W bits. If saturation is on and the exact product lies outside the lane range, the result saturates instead. The lane range is -2^(W-1) to 2^(W-1)-1 for signed mode and 0 to 2^W-1 otherwise.
- R9: A left amount of W or more yields 0 when the lane is zero or saturation is off. Otherwise the result saturates.
- R10: A saturated result takes one of three values:
  - 2^(W-1)-1 for a non-negative signed lane;
  - 2^(W-1) (the most negative lane value) for a negative signed lane;
  - all W bits set in the other modes.
- R11: In signed-to-unsigned mode with saturation on, a negative lane yields 0 and saturates. In every other case that mode treats the lane bits as unsigned.
- R12: `sat_flag` is set at the edge that registers a saturating result and otherwise keeps its value. `sat_clear` resets it to 0 at the next edge, except that a saturating result registered at that same edge sets it instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_src | input | 64 | Source operand; the lane is its low W bits |
| in_amt | input | 8 | Signed shift amount |
| in_size | input | 2 | Lane width select |
| in_mode | input | 2 | Interpretation select |
| in_round | input | 1 | Round right shifts to nearest |
| in_sat | input | 1 | Saturate on overflow |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 64 | Shifted lane, zero above W bits |
| sat_clear | input | 1 | Clear the sticky saturation flag |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
A corrupt state register shows up within one cycle as one of three port symptoms:

- `out_valid` disagrees with the accept history;
- `in_ready` drops while the output is empty;
- a result is lost or repeated under a stall.

Every one of these is visible on the next falling edge. A wrong sticky bit is visible on `sat_flag` in the very cycle after the edge that should have set, kept or cleared it. Data-path faults in rounding, limit comparisons or saturation choice show as a wrong `out_data` for the first lane that reaches the affected corner. The bench therefore hits each corner deliberately before running a long mixed stream with random stalls.

// File: rtl/lane_shift_pkg.sv
package lane_shift_pkg;

    typedef enum logic [1:0] {
        MODE_SIGNED   = 2'd0,
        MODE_UNSIGNED = 2'd1,
        MODE_S2U      = 2'd2,
        MODE_UNS_ALT  = 2'd3
    } shift_mode_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } pipe_state_e;

endpackage

// File: rtl/lane_shift_core.sv
module lane_shift_core
    import lane_shift_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int AMT_W  = 8,
    parameter int SIZE_W = 2
) (
    input  logic [DATA_W-1:0] src,
    input  logic [AMT_W-1:0]  amt,
    input  logic [SIZE_W-1:0] size,
    input  logic [1:0]        mode,
    input  logic              rnd,
    input  logic              sat_en,
    output logic [DATA_W-1:0] res,
    output logic              res_sat
);

    localparam int EXT_W = 2 * DATA_W + 2;

    int                      w;
    int                      a;
    int                      n;
    int                      lim;
    logic [EXT_W-1:0]        mask;
    logic [EXT_W-1:0]        xu;
    logic signed [EXT_W-1:0] xs;
    logic signed [EXT_W-1:0] x;
    logic signed [EXT_W-1:0] t;
    logic signed [EXT_W-1:0] h;
    logic signed [EXT_W-1:0] ex;
    logic [EXT_W-1:0]        tr;
    logic [EXT_W-1:0]        ext;
    logic [EXT_W-1:0]        satv;
    logic [EXT_W-1:0]        r;
    logic                    neg;
    logic                    sgn;

    always_comb begin
        w    = 8 << size;
        a    = $signed(amt);
        n    = 0;
        lim  = 0;
        mask = (EXT_W'(1) << w) - EXT_W'(1);
        xu   = EXT_W'(src) & mask;
        neg  = xu[w-1];
        xs   = neg ? (xu | ~mask) : xu;
        sgn  = (mode == MODE_SIGNED);
        x    = sgn ? xs : $signed(xu);
        t    = '0;
        h    = '0;
        ex   = '0;
        tr   = '0;
        ext  = '0;
        r    = '0;
        res_sat = 1'b0;
        satv = sgn ? (neg ? (EXT_W'(1) << (w - 1)) : (mask >> 1)) : mask;

        if (mode == MODE_S2U && sat_en && neg) begin
            res_sat = 1'b1;
        end else if (a < 0) begin
            n   = -a;
            lim = sgn ? w : w + int'(rnd);
            if (n >= lim) begin
                r = (sgn && !rnd && neg) ? '1 : '0;
            end else if (rnd) begin
                t = x >>> (n - 1);
                h = t >>> 1;
                r = h + {{(EXT_W-1){1'b0}}, t[0]};
            end else begin
                r = x >>> n;
            end
        end else if (a < w) begin
            ex  = x <<< a;
            tr  = ex & mask;
            ext = (sgn && tr[w-1]) ? (tr | ~mask) : tr;
            if (sat_en && ext != ex) begin
                res_sat = 1'b1;
                r       = satv;
            end else begin
                r = ext;
            end
        end else if (sat_en && xu != '0) begin
            res_sat = 1'b1;
            r       = satv;
        end

        res = r[DATA_W-1:0] & mask[DATA_W-1:0];
    end

endmodule

// File: rtl/lane_shift_ctrl.sv
module lane_shift_ctrl
    import lane_shift_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    input  logic [DATA_W-1:0] core_res,
    input  logic              core_sat,
    input  logic              sat_clear,
    output logic [DATA_W-1:0] out_data,
    output logic              sat_flag
);

    pipe_state_e       state_q;
    pipe_state_e       state_d;
    logic              accept;
    logic [DATA_W-1:0] data_q;
    logic              flag_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // next state: LOAD, REFILL, STALL, DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_FULL;
            ST_FULL:  if (out_ready && !accept) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        out_valid = (state_q == ST_FULL);
        in_ready  = (state_q == ST_EMPTY) || out_ready;
        accept    = in_valid && in_ready;
        out_data  = data_q;
        sat_flag  = flag_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (accept) data_q <= core_res;
            if (accept && core_sat) flag_q <= 1'b1;
            else if (sat_clear)     flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/sat_shift_lane.sv
module sat_shift_lane
    import lane_shift_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int AMT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_src,
    input  logic [AMT_W-1:0]  in_amt,
    input  logic [1:0]        in_size,
    input  logic [1:0]        in_mode,
    input  logic              in_round,
    input  logic              in_sat,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    input  logic              sat_clear,
    output logic              sat_flag
);

    logic [DATA_W-1:0] core_res;
    logic              core_sat;

    lane_shift_core #(
        .DATA_W (DATA_W),
        .AMT_W  (AMT_W),
        .SIZE_W (2)
    ) u_core (
        .src     (in_src),
        .amt     (in_amt),
        .size    (in_size),
        .mode    (in_mode),
        .rnd     (in_round),
        .sat_en  (in_sat),
        .res     (core_res),
        .res_sat (core_sat)
    );

    lane_shift_ctrl #(
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .core_res  (core_res),
        .core_sat  (core_sat),
        .sat_clear (sat_clear),
        .out_data  (out_data),
        .sat_flag  (sat_flag)
    );

endmodule

// File: rtl/sat_shift_lane_chk.sv
module sat_shift_lane_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              sat_clear,
    input logic              sat_flag
);

    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    p_stall_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_drain_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);

    p_ready_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    p_ready_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> in_ready);

    p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !sat_clear) |=> sat_flag);

    p_rise_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_flag) |-> $past(in_valid && in_ready));

endmodule

bind sat_shift_lane sat_shift_lane_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .sat_clear (sat_clear),
    .sat_flag  (sat_flag)
);

// File: tb/sat_shift_lane_tb.sv
module sat_shift_lane_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_src = '0;
    logic [7:0]  in_amt = '0;
    logic [1:0]  in_size = '0;
    logic [1:0]  in_mode = '0;
    logic        in_round = 1'b0;
    logic        in_sat = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_data;
    logic        sat_clear = 1'b0;
    logic        sat_flag;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // behavioural model state
    bit          m_valid = 0;
    logic [63:0] m_data = '0;
    bit          m_flag = 0;
    string       m_tag = "R1";

    always #2 clk = ~clk;

    sat_shift_lane u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_src(in_src), .in_amt(in_amt), .in_size(in_size), .in_mode(in_mode),
        .in_round(in_round), .in_sat(in_sat), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .sat_clear(sat_clear),
        .sat_flag(sat_flag)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void ref_shift(input logic [63:0] src, input logic [7:0] amt,
                                      input logic [1:0] size, input logic [1:0] mode,
                                      input logic rnd, input logic sat,
                                      output logic [63:0] data, output bit flag);
        int w, a, n;
        logic signed [199:0] one, m, u, sv, v, e, sval;
        bit isneg, sg;
        one = 200'sd1;
        w = 8 << size;
        m = (one << w) - one;
        u = 200'(src) & m;
        isneg = u[w-1];
        sg = (mode == 2'd0);
        sv = isneg ? (u - (one << w)) : u;
        sval = sg ? (isneg ? -(one << (w-1)) : (one << (w-1)) - one) : m;
        flag = 0;
        data = '0;
        if (mode == 2'd2 && sat && isneg) begin
            flag = 1;
            return;
        end
        v = sg ? sv : u;
        a = $signed(amt);
        if (a < 0) begin
            n = -a;
            if (sg && n >= w)                      e = rnd ? 0 : (isneg ? -1 : 0);
            else if (!sg && n >= w + (rnd ? 1 : 0)) e = 0;
            else if (rnd)                          e = (v + (one << (n-1))) >>> n;
            else                                   e = v >>> n;
        end else if (a < w) begin
            e = v <<< a;
            if (sat && (sg ? (e < -(one << (w-1)) || e > (one << (w-1)) - one) : (e > m))) begin
                flag = 1;
                e = sval;
            end
        end else begin
            if (sat && v != 0) begin
                flag = 1;
                e = sval;
            end else e = 0;
        end
        data = 64'(e & m);
    endfunction

    function automatic string tag_of(input logic [63:0] src, input logic [7:0] amt,
                                     input logic [1:0] size, input logic [1:0] mode,
                                     input logic rnd, input logic sat);
        int w, a;
        w = 8 << size;
        a = $signed(amt);
        if (mode == 2'd2 && sat && src[w-1]) return "R11";
        if (a < 0) begin
            if (mode == 2'd0 && -a >= w) return "R6";
            if (mode != 2'd0 && -a >= w) return "R7";
            return rnd ? "R5" : "R4";
        end
        if (a >= w) return "R9";
        return sat ? "R10" : "R8";
    endfunction

    // one cycle: compare outputs, drive next inputs, advance the model
    task automatic step(input bit v, input logic [63:0] src, input logic [7:0] amt,
                        input logic [1:0] size, input logic [1:0] mode, input bit rnd,
                        input bit sat, input bit ordy, input bit clr);
        logic [63:0] rd;
        bit rf, acc, exp_rdy;
        @(negedge clk);
        check("R1 out_valid", 64'(out_valid), 64'(m_valid));
        if (m_valid) check({m_tag, " out_data"}, out_data, m_data);
        check("R12 sat_flag", 64'(sat_flag), 64'(m_flag));
        in_valid = v; in_src = src; in_amt = amt; in_size = size; in_mode = mode;
        in_round = rnd; in_sat = sat; out_ready = ordy; sat_clear = clr;
        #1;
        exp_rdy = !m_valid || ordy;
        check("R2 in_ready", 64'(in_ready), 64'(exp_rdy));
        acc = v && exp_rdy;
        ref_shift(src, amt, size, mode, rnd, sat, rd, rf);
        if (acc) begin
            m_valid = 1;
            m_data = rd;
            m_tag = tag_of(src, amt, size, mode, rnd, sat);
        end else if (ordy) m_valid = 0;
        if (acc && rf) m_flag = 1;
        else if (clr)  m_flag = 0;
    endtask

    task automatic op(input logic [63:0] src, input int amt, input logic [1:0] size,
                      input logic [1:0] mode, input bit rnd, input bit sat);
        step(1, src, 8'(amt), size, mode, rnd, sat, 1, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 reset out_valid", 64'(out_valid), 64'd0);
        check("R12 reset sat_flag", 64'(sat_flag), 64'd0);
        check("R2 reset in_ready", 64'(in_ready), 64'd1);

        op(64'hFFFF_FF12, 0, 0, 1, 0, 0);          // R3 upper bits dropped
        op(64'h40, 1, 0, 0, 0, 0);                 // R8 truncation wraps
        op(64'h7F, 1, 0, 0, 0, 1);                 // R10 signed positive clip
        step(0, 0, 0, 0, 0, 0, 0, 1, 1);           // R12 clear
        op(64'h80, 1, 0, 0, 0, 1);                 // R10 signed negative clip
        op(64'h8001, -1, 1, 0, 0, 0);              // R4 arithmetic right
        op(64'h8001, -1, 1, 1, 0, 0);              // R4 logical right
        op(64'h3, -1, 2, 0, 1, 0);                 // R5 round up to 2
        op(64'hFFFF_FFFD, -1, 2, 0, 1, 0);         // R5 negative rounding
        op(64'h80, -8, 0, 0, 0, 0);                // R6 sign fill
        op(64'h80, -8, 0, 0, 1, 0);                // R6 rounding gives 0
        op(64'h80, -128, 0, 0, 0, 0);              // R6 extreme amount
        op(64'h80, -8, 0, 1, 1, 0);                // R7 n=W with rounding gives 1
        op(64'h80, -9, 0, 1, 1, 0);                // R7 beyond limit
        op(64'h80, -8, 0, 1, 0, 0);                // R7 n=W without rounding
        step(1, 0, 0, 0, 0, 0, 0, 1, 1);           // R12 clear while no saturation
        op(64'h0, 64, 3, 1, 0, 1);                 // R9 zero lane
        op(64'h1, 64, 3, 1, 0, 0);                 // R9 no saturation
        step(1, 64'h1, 8'd64, 3, 1, 0, 1, 1, 1);   // R9/R12 saturate wins over clear
        op(64'h1, 127, 3, 0, 0, 1);                // R10 signed max 64-bit
        op(64'hFF, 0, 0, 2, 0, 1);                 // R11 negative to zero
        op(64'hFF, 0, 0, 2, 0, 0);                 // R11 no sat, bits as unsigned
        op(64'h40, 1, 0, 2, 0, 1);                 // R11 fits unsigned range
        // R1 stall and R2 back-to-back
        op(64'h11, 1, 1, 1, 0, 0);
        step(1, 64'h22, 8'd1, 1, 1, 0, 0, 0, 0);
        step(1, 64'h33, 8'd1, 1, 1, 0, 0, 0, 0);
        step(1, 64'h44, 8'd1, 1, 1, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0, 0, 0, 1, 0);

        for (int i = 0; i < 6000; i++) begin
            logic [63:0] s;
            logic [7:0] am;
            s = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) s = 64'($urandom_range(0, 5));
            am = 8'($urandom);
            if ($urandom_range(0, 1) == 0) am = 8'($signed(7'($urandom_range(0, 127))) );
            step($urandom_range(0, 3) != 0, s, am, 2'($urandom), 2'($urandom),
                 1'($urandom), 1'($urandom), $urandom_range(0, 3) != 0,
                 $urandom_range(0, 15) == 0);
        end
        step(0, 0, 0, 0, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0, 0, 0, 1, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule